// File: doc/BRIEF.md
# Floating-Point Register Stack with Tags

This block holds the eight 80-bit working registers of a stack-oriented floating-point unit. Software names them ST0 to ST7, counted from the current stack top. A 3-bit top pointer moves down on a push and up on a pop, modulo eight. No data moves between physical registers, so every stack operation finishes in a single clock.

A 2-bit tag per physical register records whether the register holds a value. Code 00 means valid and code 11 means empty. Reads and pops of empty entries raise an underflow pulse. A push into an occupied slot raises an overflow pulse. A faulting operation leaves the pointer, the tags and the data unchanged.

The same storage is also reachable through a 64-bit packed-integer view, addressed by physical register number. That view reaches the low 64 bits of each register, and any access through it marks all eight tags valid. A bulk command marks all eight tags empty. Initialization also returns the top pointer to zero.

Top module: `fpstk_file`

## Requirements
- R1: After reset, `top_ptr` is 0, every tag reads 11 (empty), and `rd_data`, `simd_rdata`, `ovf` and `unf` are all zero. In `tag_word`, bits [2p+1:2p] hold the tag of physical register p: 00 is valid and 11 is empty. An `op` of 0 (idle), or any code above 9, changes nothing.
- R2: Push (`op`=1) acts only when the destination slot, physical (top-1) mod 8, is empty. It writes `wr_data` there, marks that slot valid, and decrements `top_ptr` modulo 8. Each former ST(i) then reads as ST(i+1).
- R3: A push whose destination slot is valid raises `ovf` for one cycle, in the cycle after the command. Pointer, tags and data stay unchanged.
- R4: Pop (`op`=2) on a valid ST0 does three things in the cycle after the command. It places the old ST0 on `rd_data`, marks that slot empty, and increments `top_ptr` modulo 8.
- R5: Any of these raises `unf` for one cycle: a pop of an empty ST0, a read of an empty ST(i), or an exchange where either operand is empty. In every such case the pointer, tags, data and `rd_data` are left unchanged. `ovf` and `unf` are never high together.
- R6: Read (`op`=3) places ST(`idx`) on `rd_data` one cycle later and leaves pointer and tags unchanged. Between loads, `rd_data` holds its value.
- R7: Write (`op`=4) replaces ST(`idx`) with `wr_data` and marks it valid, whatever its previous tag. The pointer is unchanged.
- R8: Exchange (`op`=5) swaps the contents of ST0 and ST(`idx`) when both are valid. An `idx` of 0 leaves the stack as it was.
- R9: Initialize (`op`=6) sets `top_ptr` to 0 and all tags to 11.
- R10: Empty-all (`op`=7) sets all tags to 11. It leaves `top_ptr` and the register contents unchanged.
- R11: Packed read (`op`=8) places bits [63:0] of physical register `simd_idx` on `simd_rdata` one cycle later. It sets all tags to 00 and does not move the pointer.
- R12: Packed write (`op`=9) writes {16'hFFFF, `simd_wdata`} into physical register `simd_idx` and sets all tags to 00. It raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op | input | 4 | Command code (0 idle, 1 push, 2 pop, 3 read, 4 write, 5 exchange, 6 init, 7 empty-all, 8 packed read, 9 packed write) |
| idx | input | 3 | Stack-relative index i for read, write and exchange |
| wr_data | input | 80 | Value for push and write |
| simd_idx | input | 3 | Physical register number for packed accesses |
| simd_wdata | input | 64 | Value for packed write |
| rd_data | output | 80 | Value from the last successful pop or read |
| simd_rdata | output | 64 | Value from the last packed read |
| ovf | output | 1 | One-cycle stack overflow pulse |
| unf | output | 1 | One-cycle stack underflow pulse |
| top_ptr | output | 3 | Current physical index of ST0 |
| tag_word | output | 16 | Tags of all physical registers, two bits each |

## Verification
The first directed pattern fills all eight slots and then pushes once more. This separates correct top-relative addressing from physical addressing and checks the overflow boundary. Pops run down to an empty stack and then one further pop, which tests underflow with the pointer held still. Exchanges with index 0 and index 7 check that the operand mapping wraps correctly at the ends. The sequence that empties all tags and then does a packed access checks that the two bulk tag rewrites behave differently. Random mixes of all ten commands follow, compared each cycle against a behavioural model. These mixes catch pointer drift and wrong tag updates that only appear after many commands.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_PUSH    = 4'd1,
    OP_POP     = 4'd2,
    OP_READ    = 4'd3,
    OP_WRITE   = 4'd4,
    OP_XCHG    = 4'd5,
    OP_INIT    = 4'd6,
    OP_EMPTY   = 4'd7,
    OP_SIMD_RD = 4'd8,
    OP_SIMD_WR = 4'd9
  } op_e;

  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;
endpackage

// File: rtl/fpstk_ptr.sv
module fpstk_ptr #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [PW-1:0] top
);
  logic [PW-1:0] top_d;
  logic          top_en;

  always_comb begin
    top_en = clr | inc | dec;
    top_d  = top;
    if (clr)      top_d = '0;
    else if (inc) top_d = top + PW'(1);
    else if (dec) top_d = top - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top <= '0;
    else if (top_en) top <= top_d;
  end
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags #(
  parameter int NREG = 8,
  parameter int PW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 all_empty,
  input  logic                 all_valid,
  input  logic                 mark_valid,
  input  logic [PW-1:0]        valid_addr,
  input  logic                 mark_empty,
  input  logic [PW-1:0]        empty_addr,
  output logic [NREG-1:0][1:0] tags
);
  import fpstk_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_tag
    logic [1:0] tag_d;
    logic       tag_en;

    always_comb begin
      tag_en = 1'b0;
      tag_d  = tags[g];
      if (all_empty) begin
        tag_en = 1'b1;
        tag_d  = TAG_EMPTY;
      end else if (all_valid) begin
        tag_en = 1'b1;
        tag_d  = TAG_VALID;
      end else if (mark_valid && valid_addr == PW'(g)) begin
        tag_en = 1'b1;
        tag_d  = TAG_VALID;
      end else if (mark_empty && empty_addr == PW'(g)) begin
        tag_en = 1'b1;
        tag_d  = TAG_EMPTY;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tags[g] <= TAG_EMPTY;
      else if (tag_en) tags[g] <= tag_d;
    end
  end
endmodule

// File: rtl/fpstk_data.sv
module fpstk_data #(
  parameter int NREG = 8,
  parameter int PW   = 3,
  parameter int DW   = 80
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [PW-1:0] wa_addr,
  input  logic [DW-1:0] wa_data,
  input  logic          wb_en,
  input  logic [PW-1:0] wb_addr,
  input  logic [DW-1:0] wb_data,
  input  logic [PW-1:0] ra_addr,
  input  logic [PW-1:0] rb_addr,
  input  logic [PW-1:0] rs_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data,
  output logic [DW-1:0] rs_data
);
  logic [NREG-1:0][DW-1:0] regs;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] reg_d;
    logic          reg_en;

    always_comb begin
      reg_en = 1'b0;
      reg_d  = regs[g];
      if (wa_en && wa_addr == PW'(g)) begin
        reg_en = 1'b1;
        reg_d  = wa_data;
      end else if (wb_en && wb_addr == PW'(g)) begin
        reg_en = 1'b1;
        reg_d  = wb_data;
      end
    end

    always_ff @(posedge clk) begin
      if (reg_en) regs[g] <= reg_d;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
  assign rs_data = regs[rs_addr];
endmodule

// File: rtl/fpstk_file.sv
module fpstk_file #(
  parameter int NREG = 8,
  parameter int DW   = 80,
  parameter int SW   = 64,
  parameter int IW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        op,
  input  logic [$clog2(NREG)-1:0] idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [$clog2(NREG)-1:0] simd_idx,
  input  logic [SW-1:0]        simd_wdata,
  output logic [DW-1:0]        rd_data,
  output logic [SW-1:0]        simd_rdata,
  output logic                 ovf,
  output logic                 unf,
  output logic [$clog2(NREG)-1:0] top_ptr,
  output logic [2*NREG-1:0]    tag_word
);
  import fpstk_pkg::*;

  localparam int PW = $clog2(NREG);
  localparam int HW = DW - SW;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [PW-1:0]           top;
  logic [NREG-1:0][1:0]    tags;
  logic [PW-1:0]           ph_idx, ph_new;
  logic [DW-1:0]           top_val, idx_val, simd_val;
  logic                    top_empty, idx_empty, new_busy;

  assign ph_idx    = top + idx;
  assign ph_new    = top - PW'(1);
  assign top_empty = (tags[top]    == TAG_EMPTY);
  assign idx_empty = (tags[ph_idx] == TAG_EMPTY);
  assign new_busy  = (tags[ph_new] != TAG_EMPTY);

  // decoded controls
  logic          p_clr, p_inc, p_dec;
  logic          t_all_e, t_all_v, t_mv, t_me;
  logic [PW-1:0] t_mv_a;
  logic          wa_en, wb_en;
  logic [PW-1:0] wa_addr;
  logic [DW-1:0] wa_data;
  logic          ovf_d, unf_d, rd_ld, srd_ld;
  logic [DW-1:0] rd_d;
  op_e           cmd;

  assign cmd = op_e'(op);

  always_comb begin
    p_clr   = 1'b0; p_inc = 1'b0; p_dec = 1'b0;
    t_all_e = 1'b0; t_all_v = 1'b0; t_mv = 1'b0; t_me = 1'b0;
    t_mv_a  = ph_idx;
    wa_en   = 1'b0; wb_en = 1'b0;
    wa_addr = ph_idx;
    wa_data = wr_data;
    ovf_d   = 1'b0; unf_d = 1'b0;
    rd_ld   = 1'b0; srd_ld = 1'b0;
    rd_d    = idx_val;
    unique case (cmd)
      OP_PUSH: begin
        if (new_busy) ovf_d = 1'b1;
        else begin
          p_dec   = 1'b1;
          wa_en   = 1'b1;
          wa_addr = ph_new;
          t_mv    = 1'b1;
          t_mv_a  = ph_new;
        end
      end
      OP_POP: begin
        if (top_empty) unf_d = 1'b1;
        else begin
          p_inc = 1'b1;
          t_me  = 1'b1;
          rd_ld = 1'b1;
          rd_d  = top_val;
        end
      end
      OP_READ: begin
        if (idx_empty) unf_d = 1'b1;
        else           rd_ld = 1'b1;
      end
      OP_WRITE: begin
        wa_en = 1'b1;
        t_mv  = 1'b1;
      end
      OP_XCHG: begin
        if (top_empty || idx_empty) unf_d = 1'b1;
        else begin
          wa_en   = 1'b1;
          wa_addr = top;
          wa_data = idx_val;
          wb_en   = 1'b1;
        end
      end
      OP_INIT: begin
        p_clr   = 1'b1;
        t_all_e = 1'b1;
      end
      OP_EMPTY: t_all_e = 1'b1;
      OP_SIMD_RD: begin
        t_all_v = 1'b1;
        srd_ld  = 1'b1;
      end
      OP_SIMD_WR: begin
        t_all_v = 1'b1;
        wa_en   = 1'b1;
        wa_addr = simd_idx;
        wa_data = {{HW{1'b1}}, simd_wdata};
      end
      default: ;
    endcase
  end

  fpstk_ptr #(.PW(PW)) u_ptr (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (p_clr),
    .inc  (p_inc),
    .dec  (p_dec),
    .top  (top)
  );

  fpstk_tags #(.NREG(NREG), .PW(PW)) u_tags (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .all_empty (t_all_e),
    .all_valid (t_all_v),
    .mark_valid(t_mv),
    .valid_addr(t_mv_a),
    .mark_empty(t_me),
    .empty_addr(top),
    .tags      (tags)
  );

  fpstk_data #(.NREG(NREG), .PW(PW), .DW(DW)) u_data (
    .clk    (clk),
    .wa_en  (wa_en),
    .wa_addr(wa_addr),
    .wa_data(wa_data),
    .wb_en  (wb_en),
    .wb_addr(ph_idx),
    .wb_data(top_val),
    .ra_addr(top),
    .rb_addr(ph_idx),
    .rs_addr(simd_idx),
    .ra_data(top_val),
    .rb_data(idx_val),
    .rs_data(simd_val)
  );

  // registered result and flag outputs
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_data    <= '0;
      simd_rdata <= '0;
      ovf        <= 1'b0;
      unf        <= 1'b0;
    end else begin
      ovf <= ovf_d;
      unf <= unf_d;
      if (rd_ld)  rd_data    <= rd_d;
      if (srd_ld) simd_rdata <= simd_val[SW-1:0];
    end
  end

  assign top_ptr  = top;
  assign tag_word = tags;
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
  parameter int NREG = 8,
  parameter int IW   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [IW-1:0]           op,
  input logic                    ovf,
  input logic                    unf,
  input logic [$clog2(NREG)-1:0] top_ptr,
  input logic [2*NREG-1:0]       tag_word
);
  import fpstk_pkg::*;
  localparam int PW = $clog2(NREG);

  assert_push_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> (ovf ? (top_ptr == $past(top_ptr))
                             : (top_ptr == PW'($past(top_ptr) - PW'(1)))));

  assert_no_overflow_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PUSH) |=> (!ovf || $stable(tag_word)));

  assert_pop_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_POP) |=> (unf ? ($stable(top_ptr) && $stable(tag_word))
                            : (top_ptr == PW'($past(top_ptr) + PW'(1)))));

  assert_unf_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> ($past(op) == OP_POP || $past(op) == OP_READ || $past(op) == OP_XCHG));

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf}));

  assert_read_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |=> ($stable(top_ptr) && $stable(tag_word)));

  assert_init_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INIT) |=> (top_ptr == '0 && tag_word == '1));

  assert_empty_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EMPTY) |=> (tag_word == '1 && $stable(top_ptr)));

  assert_simd_tags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SIMD_RD || op == OP_SIMD_WR) |=> (tag_word == '0 && !ovf && !unf && $stable(top_ptr)));
endmodule

bind fpstk_file fpstk_chk #(.NREG(NREG), .IW(IW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .op      (op),
  .ovf     (ovf),
  .unf     (unf),
  .top_ptr (top_ptr),
  .tag_word(tag_word)
);

// File: tb/fpstk_file_tb_top.sv
`timescale 1ns/1ps
module fpstk_file_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [2:0]  idx, simd_idx;
  logic [79:0] wr_data, rd_data;
  logic [63:0] simd_wdata, simd_rdata;
  logic        ovf, unf;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;

  always #2 clk = ~clk;

  fpstk_file dut_i (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(idx), .wr_data(wr_data),
    .simd_idx(simd_idx), .simd_wdata(simd_wdata), .rd_data(rd_data),
    .simd_rdata(simd_rdata), .ovf(ovf), .unf(unf), .top_ptr(top_ptr),
    .tag_word(tag_word)
  );

  int unsigned n_chk = 0, n_err = 0;
  bit done = 0;

  // behavioural model
  logic [79:0] m_reg [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top;
  logic [79:0] e_rd;
  logic [63:0] e_srd;
  logic        e_ovf, e_unf;

  function automatic logic [15:0] m_tagword();
    logic [15:0] w;
    for (int p = 0; p < 8; p++) w[2*p +: 2] = m_tag[p];
    return w;
  endfunction

  function automatic void model(input logic [3:0] o, input logic [2:0] i,
                                input logic [79:0] w, input logic [2:0] si,
                                input logic [63:0] sw);
    logic [2:0] p, np;
    logic [79:0] t;
    p = m_top + i;
    np = m_top - 3'd1;
    e_ovf = 0; e_unf = 0;
    case (o)
      4'd1: if (m_tag[np] != 2'b11) e_ovf = 1;
            else begin m_reg[np] = w; m_tag[np] = 2'b00; m_top = np; end
      4'd2: if (m_tag[m_top] == 2'b11) e_unf = 1;
            else begin e_rd = m_reg[m_top]; m_tag[m_top] = 2'b11; m_top = m_top + 3'd1; end
      4'd3: if (m_tag[p] == 2'b11) e_unf = 1; else e_rd = m_reg[p];
      4'd4: begin m_reg[p] = w; m_tag[p] = 2'b00; end
      4'd5: if (m_tag[p] == 2'b11 || m_tag[m_top] == 2'b11) e_unf = 1;
            else begin t = m_reg[p]; m_reg[p] = m_reg[m_top]; m_reg[m_top] = t; end
      4'd6: begin m_top = 0; for (int k = 0; k < 8; k++) m_tag[k] = 2'b11; end
      4'd7: for (int k = 0; k < 8; k++) m_tag[k] = 2'b11;
      4'd8: begin e_srd = m_reg[si][63:0]; for (int k = 0; k < 8; k++) m_tag[k] = 2'b00; end
      4'd9: begin m_reg[si] = {16'hFFFF, sw}; for (int k = 0; k < 8; k++) m_tag[k] = 2'b00; end
      default: ;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [79:0] act,
                     input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare every output against the model; req names the requirement
  task automatic check_all(input string req);
    chk(req, "rd_data", rd_data, e_rd);
    chk(req, "simd_rdata", 80'(simd_rdata), 80'(e_srd));
    chk(req, "ovf", 80'(ovf), 80'(e_ovf));
    chk(req, "unf", 80'(unf), 80'(e_unf));
    chk(req, "top_ptr", 80'(top_ptr), 80'(m_top));
    chk(req, "tag_word", 80'(tag_word), 80'(m_tagword()));
  endtask

  // called at a falling edge; drives, waits one cycle, checks
  task automatic step(input string req, input logic [3:0] o, input logic [2:0] i,
                      input logic [79:0] w, input logic [2:0] si = 0,
                      input logic [63:0] sw = 0);
    op = o; idx = i; wr_data = w; simd_idx = si; simd_wdata = sw;
    model(o, i, w, si, sw);
    @(negedge clk);
    check_all(req);
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0291));
    op = 0; idx = 0; wr_data = 0; simd_idx = 0; simd_wdata = 0;
    rst_n = 1'b0;
    m_top = 0; e_rd = 0; e_srd = 0; e_ovf = 0; e_unf = 0;
    for (int k = 0; k < 8; k++) begin m_tag[k] = 2'b11; m_reg[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");                                   // reset state
    step("R1", 4'd0, 3'd0, 80'h0);                     // idle
    step("R1", 4'd12, 3'd2, 80'h5);                    // unused code
    // R2: fill all eight slots
    for (int k = 0; k < 8; k++) step("R2", 4'd1, 3'd0, 80'h1000 + 80'(k) * 80'h1_0001);
    // R3: ninth push overflows
    step("R3", 4'd1, 3'd0, 80'hDEAD);
    // R6: read every ST(i), checks top-relative mapping
    for (int k = 0; k < 8; k++) step("R6", 4'd3, 3'(k), 80'h0);
    // R8: exchange with ST7 and with itself
    step("R8", 4'd5, 3'd7, 80'h0);
    step("R8", 4'd3, 3'd0, 80'h0);
    step("R8", 4'd5, 3'd0, 80'h0);
    step("R8", 4'd3, 3'd7, 80'h0);
    // R4: pop all then R5 underflow pop
    for (int k = 0; k < 8; k++) step("R4", 4'd2, 3'd0, 80'h0);
    step("R5", 4'd2, 3'd0, 80'h0);
    step("R5", 4'd3, 3'd4, 80'h0);
    step("R5", 4'd5, 3'd1, 80'h0);
    // R7: write into empty slot makes it valid
    step("R7", 4'd4, 3'd3, rnd80());
    step("R7", 4'd3, 3'd3, 80'h0);
    // R12 and R11: packed view
    step("R12", 4'd9, 3'd0, 80'h0, 3'd5, 64'h0123_4567_89AB_CDEF);
    step("R11", 4'd8, 3'd0, 80'h0, 3'd5);
    step("R12", 4'd3, 3'(5 - int'(m_top)), 80'h0);     // upper 16 bits all ones
    // R10: empty-all keeps pointer, then read underflows
    step("R2", 4'd1, 3'd0, rnd80());
    step("R10", 4'd7, 3'd0, 80'h0);
    step("R10", 4'd3, 3'd0, 80'h0);
    step("R11", 4'd8, 3'd0, 80'h0, 3'd2);
    step("R9", 4'd6, 3'd0, 80'h0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [3:0] o;
      r = $urandom() % 32;
      if (r < 8) o = 4'd1;
      else if (r < 14) o = 4'd2;
      else if (r < 18) o = 4'd3;
      else if (r < 21) o = 4'd4;
      else if (r < 25) o = 4'd5;
      else if (r < 27) o = 4'd8;
      else if (r < 29) o = 4'd9;
      else if (r < 30) o = 4'd7;
      else if (r < 31) o = 4'd6;
      else o = 4'd0;
      step("R2-random", o, 3'($urandom()), rnd80(), 3'($urandom()),
           {$urandom(), $urandom()});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule